// File: doc/BRIEF.md
# Self-Correcting Decoded Johnson Counter

A divide-by-eight counter built as a four-stage twisted ring. The ring's pattern is decoded into eight active-high select lines, exactly one of which is high in each valid state, plus an active-low carry that is low for the upper half of the cycle. The carry can feed the rising-edge count input of a following counter for cascading.

Counting is controlled by two level inputs that a free-running system clock samples. One counts on its rising edge and the other on its falling edge, and each acts as the enable of the other. Both pass through a two-flop synchroniser before edge detection. An active-high clear forces state 0 at once. A synchronous seed port loads a raw stage pattern so that corrupted ring contents can be set up on purpose. Any pattern outside the ring is folded back into the ring by the next count.

Top module: `johnson_div8`

## Requirements
- R1: While `clear` is high, `dec_o` is 0x01 and `carry_n_o` is 1 at once, whatever the count inputs do. Count edges seen during the two clock edges after `clear` falls are ignored.
- R2: A rising transition of `cnt_rise` while `cnt_fall` is low advances the state by one. The outputs change on the third rising `clk` edge after the input change.
- R3: A falling transition of `cnt_fall` while `cnt_rise` is high advances the state by one.
- R4: Any other transition leaves the state and outputs unchanged. This covers `cnt_rise` rising while `cnt_fall` is high, `cnt_fall` falling while `cnt_rise` is low, `cnt_rise` falling and `cnt_fall` rising.
- R5: When both inputs give a qualifying edge in the same clock cycle, the state advances by exactly one.
- R6: In valid state k (0..7), only `dec_o[k]` is high. The state order is 0,1,...,7,0, and the high bit moves from k to k+1 with no clock cycle in which no bit is high.
- R7: `carry_n_o` is low in states 4 to 7 and high in states 0 to 3, so it rises at the 7-to-0 wrap.
- R8: `seed_we` high at a clock edge outside reset loads `seed_val` as the stage pattern, with bit i being stage i. The valid patterns 0000, 0001, 0011, 0111, 1111, 1110, 1100 and 1000 are states 0 to 7.
- R9: From any of the eight other patterns, the counter is back in the valid sequence within 11 count events. The state stays unchanged until a count event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| clear | input | 1 | Active-high master clear, asserted asynchronously and released synchronously |
| cnt_rise | input | 1 | Count input, active on its rising edge while cnt_fall is low |
| cnt_fall | input | 1 | Count input, active on its falling edge while cnt_rise is high |
| seed_we | input | 1 | Load strobe for the raw stage pattern |
| seed_val | input | 4 | Stage pattern to load, bit i is stage i |
| dec_o | output | 8 | One-hot decoded state, bit k high in state k |
| carry_n_o | output | 1 | Active-low carry, low in states 4 to 7 |

## Verification
The hardest situation to reach from the ports is a ring holding a pattern that normal counting never produces. The bench uses the seed port to place each of the eight off-ring patterns, then applies count pulses until the outputs show state 0. It then checks that the number of pulses stays within the bound. The coincident-edge case is also hard to reach: both inputs are flipped in the same cycle, from cnt_rise low and cnt_fall high to the opposite pair, so that both detectors fire together. Edges that arrive during the reset-release window are produced by raising a count input one cycle before clear falls.

// File: rtl/jdc_pkg.sv
package jdc_pkg;

  // Number of neighbouring stage pairs whose bits differ.
  function automatic int unsigned jdc_flips(input logic [31:0] q, input int unsigned n);
    int unsigned c;
    c = 0;
    for (int unsigned i = 0; i < 31; i++) begin
      if ((i + 1 < n) && (q[i] != q[i+1])) c++;
    end
    return c;
  endfunction

  // A ring pattern holds at most one boundary between ones and zeros.
  function automatic logic jdc_on_ring(input logic [31:0] q, input int unsigned n);
    return jdc_flips(q, n) <= 1;
  endfunction

  // Next pattern for one count: twisted shift on the ring, otherwise fold to all-zero.
  function automatic logic [31:0] jdc_advance(input logic [31:0] q, input int unsigned n);
    logic [31:0] mask;
    mask = (32'd1 << n) - 32'd1;
    if (jdc_on_ring(q, n)) return ((q << 1) | {31'd0, ~q[n-1]}) & mask;
    return 32'd0;
  endfunction

endpackage

// File: rtl/jdc_sync.sv
module jdc_sync #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] prev
);
  logic [DEPTH:0][WIDTH-1:0] pipe;

  for (genvar s = 0; s <= DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) pipe[0] <= din;
    end else begin : g_next
      always_ff @(posedge clk) pipe[s] <= pipe[s-1];
    end
  end

  assign level = pipe[DEPTH-1];
  assign prev  = pipe[DEPTH];
endmodule

// File: rtl/jdc_reset_sync.sv
module jdc_reset_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic clear,
  output logic hold
);
  logic [DEPTH-1:0] chain;

  always_ff @(posedge clk or posedge clear) begin
    if (clear) chain <= '1;
    else       chain <= {chain[DEPTH-2:0], 1'b0};
  end

  assign hold = chain[DEPTH-1];
endmodule

// File: rtl/jdc_trigger.sv
module jdc_trigger (
  input  logic up_now,
  input  logic up_was,
  input  logic dn_now,
  input  logic dn_was,
  output logic rise_hit,
  output logic fall_hit,
  output logic advance
);
  // rising count input is enabled while the other input sits low
  assign rise_hit = up_now & ~up_was & ~dn_now;
  // falling count input is enabled while the other input sits high
  assign fall_hit = dn_was & ~dn_now & up_now;
  assign advance  = rise_hit | fall_hit;
endmodule

// File: rtl/jdc_core.sv
module jdc_core
  import jdc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           clear,
  input  logic           hold,
  input  logic           advance,
  input  logic           seed_we,
  input  logic [N-1:0]   seed_val,
  output logic [2*N-1:0] dec_o,
  output logic           carry_n_o,
  output logic           state_legal
);
  localparam int L = 2 * N;
  localparam logic [L-1:0] DEC_ZERO = L'(1);

  logic [N-1:0] state, state_d;
  logic [L-1:0] dec_d;

  always_comb begin
    if (hold)         state_d = '0;
    else if (seed_we) state_d = seed_val;
    else if (advance) state_d = N'(jdc_advance(32'(state), N));
    else              state_d = state;
  end

  // each select line is one adjacent stage pair of the next pattern
  for (genvar k = 0; k < L; k++) begin : g_dec
    if (k == 0) begin : g_lo
      assign dec_d[k] = ~state_d[N-1] & ~state_d[0];
    end else if (k < N) begin : g_fill
      assign dec_d[k] = state_d[k-1] & ~state_d[k];
    end else if (k == N) begin : g_full
      assign dec_d[k] = state_d[N-1] & state_d[0];
    end else begin : g_drain
      assign dec_d[k] = ~state_d[k-N-1] & state_d[k-N];
    end
  end

  always_ff @(posedge clk or posedge clear) begin
    if (clear) begin
      state     <= '0;
      dec_o     <= DEC_ZERO;
      carry_n_o <= 1'b1;
    end else begin
      state     <= state_d;
      dec_o     <= dec_d;
      carry_n_o <= ~state_d[N-1];
    end
  end

  assign state_legal = jdc_on_ring(32'(state), N);
endmodule

// File: rtl/johnson_div8.sv
module johnson_div8 #(
  parameter int STAGES     = 4,
  parameter int SYNC_DEPTH = 2,
  parameter int RST_DEPTH  = 2
) (
  input  logic                  clk,
  input  logic                  clear,
  input  logic                  cnt_rise,
  input  logic                  cnt_fall,
  input  logic                  seed_we,
  input  logic [STAGES-1:0]     seed_val,
  output logic [2*STAGES-1:0]   dec_o,
  output logic                  carry_n_o
);
  logic [1:0] lvl_now, lvl_was;
  logic       rst_hold;
  logic       rise_hit, fall_hit, adv;
  logic       state_legal;

  jdc_sync #(.WIDTH(2), .DEPTH(SYNC_DEPTH)) sync_i (
    .clk(clk), .din({cnt_fall, cnt_rise}), .level(lvl_now), .prev(lvl_was)
  );

  jdc_reset_sync #(.DEPTH(RST_DEPTH)) rst_i (
    .clk(clk), .clear(clear), .hold(rst_hold)
  );

  jdc_trigger trig_i (
    .up_now(lvl_now[0]), .up_was(lvl_was[0]),
    .dn_now(lvl_now[1]), .dn_was(lvl_was[1]),
    .rise_hit(rise_hit), .fall_hit(fall_hit), .advance(adv)
  );

  jdc_core #(.N(STAGES)) core_i (
    .clk(clk), .clear(clear), .hold(rst_hold), .advance(adv),
    .seed_we(seed_we), .seed_val(seed_val),
    .dec_o(dec_o), .carry_n_o(carry_n_o), .state_legal(state_legal)
  );
endmodule

// File: rtl/johnson_div8_chk.sv
module johnson_div8_chk #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           clear,
  input logic           rst_hold,
  input logic           rise_hit,
  input logic           fall_hit,
  input logic           adv,
  input logic           seed_we,
  input logic           state_legal,
  input logic [2*N-1:0] dec_o,
  input logic           carry_n_o
);
  localparam int L = 2 * N;
  localparam logic [L-1:0] ONE = L'(1);

  logic [L-1:0] rot;
  assign rot = {dec_o[L-2:0], dec_o[L-1]};

  // R1
  always @(negedge clk) begin
    if (clear) begin
      clear_out_chk: assert (dec_o == ONE && carry_n_o) else $error("clear output");
    end
  end

  // R1
  release_hold_chk: assert property (@(posedge clk) disable iff (clear)
    rst_hold |=> (dec_o == ONE && carry_n_o));

  // R2
  step_rotate_chk: assert property (@(posedge clk) disable iff (clear || rst_hold)
    (adv && state_legal && !seed_we) |=> dec_o == $past(rot));

  // R5
  dual_single_chk: assert property (@(posedge clk) disable iff (clear || rst_hold)
    (rise_hit && fall_hit && state_legal && !seed_we) |=> dec_o == $past(rot));

  // R4
  idle_stable_chk: assert property (@(posedge clk) disable iff (clear || rst_hold)
    (!adv && !seed_we) |=> ($stable(dec_o) && $stable(carry_n_o)));

  // R6
  onehot_chk: assert property (@(posedge clk) disable iff (clear)
    state_legal |-> $countones(dec_o) == 1);

  // R7
  carry_half_chk: assert property (@(posedge clk) disable iff (clear)
    state_legal |-> (carry_n_o == (dec_o[L-1:N] == '0)));

  // R9
  recover_chk: assert property (@(posedge clk) disable iff (clear || rst_hold)
    (adv && !state_legal && !seed_we) |=> (dec_o == ONE && state_legal));
endmodule

bind johnson_div8 johnson_div8_chk #(.N(STAGES)) chk_i (
  .clk(clk), .clear(clear), .rst_hold(rst_hold), .rise_hit(rise_hit),
  .fall_hit(fall_hit), .adv(adv), .seed_we(seed_we), .state_legal(state_legal),
  .dec_o(dec_o), .carry_n_o(carry_n_o)
);

// File: tb/johnson_div8_tb_top.sv
module johnson_div8_tb_top;
  localparam int N = 4;
  localparam int S = 2 * N;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         clear = 1'b1, cnt_rise = 1'b0, cnt_fall = 1'b0, seed_we = 1'b0;
  logic [N-1:0] seed_val = '0;
  logic [S-1:0] dec_o;
  logic         carry_n_o;

  johnson_div8 dut_i (
    .clk(clk), .clear(clear), .cnt_rise(cnt_rise), .cnt_fall(cnt_fall),
    .seed_we(seed_we), .seed_val(seed_val), .dec_o(dec_o), .carry_n_o(carry_n_o)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ring position k as a stage pattern
  function automatic int code_of(input int k);
    if (k < N) return (1 << k) - 1;
    return ((1 << N) - 1) & ~((1 << (k - N)) - 1);
  endfunction

  function automatic int pos_of(input int code);
    for (int k = 0; k < S; k++) if (code_of(k) == code) return k;
    return -1;
  endfunction

  // reference model: sampled input history, ring position, off-ring flag
  bit h_r[$], h_f[$];
  int m_pos = 0, m_hold = 2;
  bit m_bad = 1'b0;

  always @(posedge clk) begin
    bit ev;
    h_r.push_front(cnt_rise);
    h_f.push_front(cnt_fall);
    if (h_r.size() > 4) begin void'(h_r.pop_back()); void'(h_f.pop_back()); end
    ev = 1'b0;
    if (h_r.size() == 4)
      ev = (h_r[2] && !h_r[3] && !h_f[2]) || (h_f[3] && !h_f[2] && h_r[2]);
    if (clear) begin
      m_pos = 0; m_bad = 1'b0; m_hold = 2;
    end else if (m_hold > 0) begin
      m_hold--; m_pos = 0; m_bad = 1'b0;
    end else if (seed_we) begin
      m_pos = pos_of(int'(seed_val));
      m_bad = (m_pos < 0);
    end else if (ev) begin
      if (m_bad) begin m_pos = 0; m_bad = 1'b0; end
      else m_pos = (m_pos + 1) % S;
    end
  end

  // cycle compare on every falling edge, skipped while the model is off-ring
  always @(negedge clk) begin
    if (!done && !m_bad) begin
      check("R6 model decode", 32'(dec_o), 32'(1) << m_pos);
      check("R7 model carry", 32'(carry_n_o), 32'(m_pos < N));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rise();
    cnt_rise = 1'b1; cyc(4);
    cnt_rise = 1'b0; cyc(4);
  endtask

  int bpos;

  initial begin
    cyc(5);
    check("R1 reset decode", 32'(dec_o), 32'h1);
    check("R1 reset carry", 32'(carry_n_o), 32'h1);
    clear = 1'b0;
    cyc(3);
    bpos = 0;

    // R2 and R7: ten rising pulses with the falling input low
    for (int k = 1; k <= 10; k++) begin
      pulse_rise();
      bpos = (bpos + 1) % S;
      check("R2 count", 32'(dec_o), 32'(1) << bpos);
      check("R7 carry", 32'(carry_n_o), 32'(bpos < N));
    end

    // R2 latency: change on the third rising clock edge
    cnt_rise = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R2 latency early", 32'(dec_o), 32'(1) << bpos);
    @(posedge clk); #1;
    bpos = (bpos + 1) % S;
    check("R2 latency due", 32'(dec_o), 32'(1) << bpos);
    cyc(2); cnt_rise = 1'b0; cyc(4);

    // R4: cnt_fall rising, then cnt_rise rising while cnt_fall high
    cnt_fall = 1'b1; cyc(4);
    check("R4 fall-input rise", 32'(dec_o), 32'(1) << bpos);
    cnt_rise = 1'b1; cyc(4);
    check("R4 rise blocked", 32'(dec_o), 32'(1) << bpos);

    // R3: cnt_fall falls while cnt_rise high
    cnt_fall = 1'b0; cyc(4);
    bpos = (bpos + 1) % S;
    check("R3 fall count", 32'(dec_o), 32'(1) << bpos);

    // R4: cnt_rise falls; then cnt_fall pulses while cnt_rise low
    cnt_rise = 1'b0; cyc(4);
    cnt_fall = 1'b1; cyc(4);
    cnt_fall = 1'b0; cyc(4);
    check("R4 fall blocked", 32'(dec_o), 32'(1) << bpos);

    // R5: both qualify in the same cycle
    cnt_fall = 1'b1; cyc(4);
    cnt_rise = 1'b1; cnt_fall = 1'b0; cyc(5);
    bpos = (bpos + 1) % S;
    check("R5 single step", 32'(dec_o), 32'(1) << bpos);
    cnt_rise = 1'b0; cyc(4);

    // R1: asynchronous clear mid-cycle, counting ignored while held
    #1 clear = 1'b1;
    #1 check("R1 async clear", 32'(dec_o), 32'h1);
    cyc(1);
    pulse_rise();
    check("R1 clear holds", 32'(dec_o), 32'h1);
    cnt_rise = 1'b1; cyc(1);
    clear = 1'b0; cyc(5);
    check("R1 release window", 32'(dec_o), 32'h1);
    cnt_rise = 1'b0; cyc(4);
    bpos = 0;

    // R8: load ring pattern 1110 (state 5)
    seed_val = 4'b1110; seed_we = 1'b1; cyc(1); seed_we = 1'b0; cyc(1);
    check("R8 seed decode", 32'(dec_o), 32'h20);
    check("R8 seed carry", 32'(carry_n_o), 32'h0);
    pulse_rise();
    check("R8 after seed", 32'(dec_o), 32'h40);

    // R9: every off-ring pattern returns to the ring
    for (int v = 0; v < (1 << N); v++) begin
      if (pos_of(v) < 0) begin
        int cnt;
        logic [S-1:0] snap;
        seed_val = N'(v); seed_we = 1'b1; cyc(1); seed_we = 1'b0; cyc(1);
        snap = dec_o;
        cyc(3);
        check("R9 off-ring holds", 32'(dec_o), 32'(snap));
        cnt = 0;
        pulse_rise(); cnt++;
        while (cnt < 11 && pos_of(0) >= 0 && dec_o != S'(1)) begin pulse_rise(); cnt++; end
        check("R9 recovered", 32'(dec_o), 32'h1);
        check("R9 within bound", 32'(cnt <= 11), 32'h1);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule